// File: doc/BRIEF.md
# Funct3-Ordered 32-bit Arithmetic-Logic Unit

This block is the purely combinational arithmetic-logic unit of a small single-cycle integer datapath. Two 32-bit operands and a 4-bit operation code go in, and one 32-bit result comes out. There is no clock or register inside, so the result follows the present inputs. The same unit serves register-to-register operations, register-immediate operations and the base-plus-offset address sums of loads and stores. For those address sums the surrounding datapath simply selects the add code.

The operation codes follow the ordering of the three-bit function field of the integer instruction set. Bit 3 of the code selects the alternate form of an operation: subtract instead of add, and arithmetic instead of logical right shift. One shared adder performs add, subtract and both less-than comparisons. One right-shifting barrel performs all three shifts, with bit reversal around it for left shifts. A small bitwise unit handles exclusive or, or, and and.

Top module: `alu32_core`

## Requirements
- R1: Code 4'b0000 gives A + B modulo 2^32; a carry out of bit 31 is discarded.
- R2: Code 4'b1000 gives A - B modulo 2^32.
- R3: Code 4'b0001 shifts A left by B[4:0] places and fills the vacated low bits with zeros.
- R4: Code 4'b0010 gives 1 when A < B, both read as signed two's-complement values, and 0 otherwise. Result bits 31:1 are zero.
- R5: Code 4'b0011 gives 1 when A < B, both read as unsigned values, and 0 otherwise. Result bits 31:1 are zero.
- R6: Code 4'b0100 gives the bitwise exclusive or of A and B.
- R7: Code 4'b0101 shifts A right by B[4:0] places and fills the vacated high bits with zeros.
- R8: Code 4'b1101 shifts A right by B[4:0] places and fills the vacated high bits with copies of A[31].
- R9: Code 4'b0110 gives the bitwise or of A and B, and code 4'b0111 gives the bitwise and.
- R10: Each of the six unused codes (4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1110, 4'b1111) gives a result of zero.
- R11: For the three shift codes, bits 31:5 of B have no effect on the result.
- R12: The result depends only on the present values of A, B and the code. A change at the inputs shows at the output with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select, funct3-ordered with bit 3 as the alternate-form flag |
| opnd_a | input | 32 | First operand; this is the shifted value for shifts |
| opnd_b | input | 32 | Second operand; only bits 4:0 are used as the shift amount |
| alu_out | output | 32 | Result |

## Verification
The cases hardest to reach with random operands are the comparisons where the signed and unsigned answers differ, and the carry and borrow edges at 0 and 2^32-1. Random pairs of 32-bit values rarely land there. Random stimulus also seldom drives a shift by exactly 0 or 31, or a B whose high bits are set while its low five bits are small. The stimulus therefore adds directed pairs with opposite sign bits and all-ones or all-zeros values. It also biases half of the random B values toward small numbers with random upper bits, so the shift boundaries and the ignored bits of B are hit often.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'b0000,
        OP_SLL  = 4'b0001,
        OP_SLT  = 4'b0010,
        OP_SLTU = 4'b0011,
        OP_XOR  = 4'b0100,
        OP_SRL  = 4'b0101,
        OP_OR   = 4'b0110,
        OP_AND  = 4'b0111,
        OP_SUB  = 4'b1000,
        OP_SRA  = 4'b1101
    } alu_op_e;

    typedef enum logic [1:0] {
        SHM_LEFT  = 2'b00,
        SHM_RLOG  = 2'b01,
        SHM_RARI  = 2'b10,
        SHM_IDLE  = 2'b11
    } shift_mode_e;

    typedef enum logic [1:0] {
        LGS_XOR  = 2'b00,
        LGS_OR   = 2'b01,
        LGS_AND  = 2'b10,
        LGS_ZERO = 2'b11
    } logic_sel_e;

endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic         sub_en,
    output logic [W-1:0] sum,
    output logic         lt_signed,
    output logic         lt_unsigned
);

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff       = in_b ^ {W{sub_en}};
        wide        = {1'b0, in_a} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};
        sum         = wide[W-1:0];
        lt_unsigned = sub_en & ~wide[W];
        lt_signed   = (in_a[W-1] ^ in_b[W-1]) ? in_a[W-1] : wide[W-1];
    end

    always_comb begin
        if (sub_en) begin
            AST_DIFF_RESTORES_A: assert ((sum + in_b) == in_a) else $error("difference plus B differs from A"); // R2
            AST_LTU_FROM_BORROW: assert (lt_unsigned == (in_a < in_b)) else $error("unsigned compare mismatch"); // R5
            AST_LT_SIGNED_SPLIT: assert (lt_signed == ($signed(in_a) < $signed(in_b))) else $error("signed compare mismatch"); // R4
        end
    end

endmodule

// File: rtl/alu32_shifter.sv
module alu32_shifter
    import alu32_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  data_in,
    input  logic [SW-1:0] amount,
    input  shift_mode_e   mode,
    output logic [W-1:0]  data_out
);

    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] barrel;
    logic [W-1:0] src;
    logic         fill;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_in[i]  = data_in[W-1-i];
        assign rev_out[i] = barrel[W-1-i];
    end

    always_comb begin
        src    = (mode == SHM_LEFT) ? rev_in : data_in;
        fill   = (mode == SHM_RARI) & data_in[W-1];
        barrel = src;
        for (int s = 0; s < SW; s++) begin
            if (amount[s]) begin
                barrel = (barrel >> (1 << s)) | (fill ? ~(ONES >> (1 << s)) : '0);
            end
        end
        data_out = (mode == SHM_LEFT) ? rev_out : barrel;
    end

    always_comb begin
        if (mode == SHM_LEFT) begin
            AST_SLL_LOW_CLEAR: assert ((data_out & (({{(W-1){1'b0}}, 1'b1} << amount) - 1'b1)) == '0) else $error("left shift left ones in low bits"); // R3
        end
        if (mode == SHM_RLOG && amount != '0) begin
            AST_SRL_TOP_CLEAR: assert (data_out[W-1] == 1'b0) else $error("logical right shift kept top bit"); // R7
        end
        if (mode == SHM_RARI) begin
            AST_SRA_SIGN_KEPT: assert (data_out[W-1] == data_in[W-1]) else $error("arithmetic shift lost the sign"); // R8
        end
    end

endmodule

// File: rtl/alu32_bitwise.sv
module alu32_bitwise
    import alu32_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic_sel_e   sel,
    output logic [W-1:0] res
);

    always_comb begin
        unique case (sel)
            LGS_XOR: res = in_a ^ in_b;
            LGS_OR:  res = in_a | in_b;
            LGS_AND: res = in_a & in_b;
            default: res = '0;
        endcase
    end

    always_comb begin
        if (sel == LGS_OR) begin
            AST_OR_COVERS_AND: assert ((res & in_a & in_b) == (in_a & in_b)) else $error("or lost common bits"); // R9
        end
    end

endmodule

// File: rtl/alu32_core.sv
module alu32_core
    import alu32_pkg::*;
#(
    parameter int W  = 32,
    parameter int OW = 4
) (
    input  logic [OW-1:0] op_code,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    output logic [W-1:0]  alu_out
);

    localparam int SW = $clog2(W);

    logic          sub_en;
    shift_mode_e   sh_mode;
    logic_sel_e    lg_sel;
    logic [W-1:0]  arith_sum;
    logic          lt_s;
    logic          lt_u;
    logic [W-1:0]  shift_res;
    logic [W-1:0]  logic_res;

    always_comb begin
        sub_en  = 1'b0;
        sh_mode = SHM_IDLE;
        lg_sel  = LGS_ZERO;
        unique case (op_code)
            OP_SUB, OP_SLT, OP_SLTU: sub_en  = 1'b1;
            OP_SLL:                  sh_mode = SHM_LEFT;
            OP_SRL:                  sh_mode = SHM_RLOG;
            OP_SRA:                  sh_mode = SHM_RARI;
            OP_XOR:                  lg_sel  = LGS_XOR;
            OP_OR:                   lg_sel  = LGS_OR;
            OP_AND:                  lg_sel  = LGS_AND;
            default: ;
        endcase
    end

    alu32_addsub #(.W(W)) u_addsub (
        .in_a        (opnd_a),
        .in_b        (opnd_b),
        .sub_en      (sub_en),
        .sum         (arith_sum),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    alu32_shifter #(.W(W), .SW(SW)) u_shifter (
        .data_in  (opnd_a),
        .amount   (opnd_b[SW-1:0]),
        .mode     (sh_mode),
        .data_out (shift_res)
    );

    alu32_bitwise #(.W(W)) u_bitwise (
        .in_a (opnd_a),
        .in_b (opnd_b),
        .sel  (lg_sel),
        .res  (logic_res)
    );

    always_comb begin
        unique case (op_code)
            OP_ADD, OP_SUB:         alu_out = arith_sum;
            OP_SLT:                 alu_out = {{(W-1){1'b0}}, lt_s};
            OP_SLTU:                alu_out = {{(W-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL, OP_SRA: alu_out = shift_res;
            OP_XOR, OP_OR, OP_AND:  alu_out = logic_res;
            default:                alu_out = '0;
        endcase
    end

    always_comb begin
        if (!(op_code inside {OP_ADD, OP_SLL, OP_SLT, OP_SLTU, OP_XOR,
                              OP_SRL, OP_OR, OP_AND, OP_SUB, OP_SRA})) begin
            AST_UNUSED_GIVES_ZERO: assert (alu_out == '0) else $error("unused code drove a value"); // R10
        end
        if (op_code == OP_ADD) begin
            AST_ADD_UNDOES_B: assert ((alu_out - opnd_b) == opnd_a) else $error("sum minus B differs from A"); // R1
        end
    end

endmodule

// File: tb/sim_alu32_core.sv
`timescale 1ns/1ps
module sim_alu32_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] alu_out;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #5 clk = ~clk;

    alu32_core u0 (
        .op_code (op_code),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .alu_out (alu_out)
    );

    function automatic logic [31:0] model(logic [3:0] op, logic [31:0] a, logic [31:0] b);
        logic [4:0] sh;
        sh = b[4:0];
        case (op)
            4'b0000: return a + b;
            4'b1000: return a - b;
            4'b0001: return a << sh;
            4'b0010: return {31'd0, $signed(a) < $signed(b)};
            4'b0011: return {31'd0, a < b};
            4'b0100: return a ^ b;
            4'b0101: return a >> sh;
            4'b1101: return 32'($signed(a) >>> sh);
            4'b0110: return a | b;
            4'b0111: return a & b;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag(logic [3:0] op);
        case (op)
            4'b0000: return "R1";
            4'b1000: return "R2";
            4'b0001: return "R3";
            4'b0010: return "R4";
            4'b0011: return "R5";
            4'b0100: return "R6";
            4'b0101: return "R7";
            4'b1101: return "R8";
            4'b0110, 4'b0111: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic expect_val(string req, logic [31:0] exp);
        n_checks++;
        if (alu_out !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
                     req, op_code, opnd_a, opnd_b, alu_out, exp);
        end
    endtask

    task automatic apply(logic [3:0] op, logic [31:0] a, logic [31:0] b, string req);
        @(posedge clk);
        op_code = op;
        opnd_a  = a;
        opnd_b  = b;
        @(negedge clk);
        expect_val(req, model(op, a, b));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_val("R1", 32'd0);                                  // reset state: add of zeros

        apply(4'b0000, 32'hFFFF_FFFF, 32'h0000_0001, "R1");      // carry discarded
        apply(4'b0000, 32'h0000_0030, 32'h0000_0004, "R1");      // address sum
        apply(4'b1000, 32'h0000_0000, 32'h0000_0001, "R2");      // borrow wrap
        apply(4'b0010, 32'h8000_0000, 32'h0000_0001, "R4");      // signed: negative < 1
        apply(4'b0011, 32'h8000_0000, 32'h0000_0001, "R5");      // unsigned: large !< 1
        apply(4'b0010, 32'h7FFF_FFFF, 32'h8000_0000, "R4");
        apply(4'b0011, 32'h7FFF_FFFF, 32'h8000_0000, "R5");
        apply(4'b0010, 32'h1234_5678, 32'h1234_5678, "R4");      // equal is not less
        apply(4'b0001, 32'h0000_0001, 32'h0000_001F, "R3");
        apply(4'b0001, 32'hDEAD_BEEF, 32'h0000_0000, "R3");
        apply(4'b0101, 32'h8000_0000, 32'h0000_001F, "R7");
        apply(4'b1101, 32'h8000_0000, 32'h0000_001F, "R8");
        apply(4'b1101, 32'h7000_0000, 32'h0000_0004, "R8");
        apply(4'b0100, 32'hF0F0_F0F0, 32'hFF00_FF00, "R6");
        apply(4'b0110, 32'hF0F0_F0F0, 32'h0F0F_0000, "R9");
        apply(4'b0111, 32'hF0F0_F0F0, 32'hFF00_FF00, "R9");
        // R11: upper bits of B ignored by shifts; expect a shift by 1
        apply(4'b0001, 32'h0000_0003, 32'hFFFF_FFE1, "R11");
        apply(4'b0101, 32'h8000_0000, 32'h0000_0021, "R11");
        apply(4'b1101, 32'h8000_0000, 32'hABCD_EF01, "R11");
        // R10: every unused code gives zero
        foreach (model_unused[i]) apply(model_unused[i], 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");

        // R12: change inputs between edges and look without a clock edge
        @(posedge clk);
        #1 op_code = 4'b0000; opnd_a = 32'd5; opnd_b = 32'd7;
        #1 expect_val("R12", 32'd12);
        #1 opnd_b = 32'd10;
        #1 expect_val("R12", 32'd15);

        for (int k = 0; k < 3000; k++) begin
            logic [3:0]  op;
            logic [31:0] a;
            logic [31:0] b;
            op = 4'($urandom_range(0, 15));
            a  = $urandom;
            b  = $urandom;
            if (k % 2 == 1) b = {b[31:5], 5'($urandom_range(0, 31))} & (($urandom % 2) ? 32'hFFFF_FFFF : 32'h0000_001F);
            if (k % 7 == 0) a = {a[31], 31'h7FFF_FFFF & ((k % 14 == 0) ? 31'h0 : 31'h7FFF_FFFF)};
            if (k % 11 == 0) b = a;
            apply(op, a, b, tag(op));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    logic [3:0] model_unused [6] = '{4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1110, 4'b1111};

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule